// File: doc/BRIEF.md
# Mode-Controlled FSK Tone Generator

This block produces the transmit tone of a V.23-style FSK modem as a digital sample stream for an external DAC. It runs from a 3.579545 MHz clock. A two-bit mode word and a transmit data bit choose one of four tones, a silent mid-scale output, or a zero-power state in which everything is parked at zero.

A 24-bit phase accumulator advances by a frequency word on every clock. Its top 8 bits address a computed 256-entry sine table, and the table output is registered as an unsigned offset-binary sample. When the data bit changes, only the step is replaced. The phase therefore runs on without a jump at bit edges. Both idle modes clear the accumulator, so a tone that follows always starts at phase zero.

Top module: `fsk_tone_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next `sample_o` is 128, `tone_on_o` is 0 and the phase accumulator is cleared to 0.
- R2: With mode 2'b00 (low-rate back channel), the phase step per clock is 2109 for data 0 (450 Hz) and 1828 for data 1 (390 Hz).
- R3: With mode 2'b01 (1200 bit/s forward channel), the phase step per clock is 9843 for data 0 (2100 Hz) and 6093 for data 1 (1300 Hz).
- R4: Each step equals round(f * 2^24 / 3579545). The resulting tones fall inside 448–452 Hz, 388–392 Hz, 2097–2103 Hz and 1297–1303 Hz.
- R5: In a tone mode, `sample_o` after an edge is S(a), where a is bits 23:16 of the accumulator before that edge. Let q = a mod 128 and m = floor(127*16q(128-q) / (81920 - 4q(128-q))). Then S(a) = 128+m for a < 128 and 128-m otherwise.
- R6: A change of `txd_i` within a tone mode does not reset or shift the accumulator. Only the step taken from the next edge on changes.
- R7: With mode 2'b10 (transmit off), the next `sample_o` is 128 and the accumulator is cleared.
- R8: With mode 2'b11 (zero power), the next `sample_o` is 0, `tone_on_o` is 0 and the accumulator is cleared.
- R9: `tone_on_o` is 1 after an edge at which the mode was 2'b00 or 2'b01, and 0 otherwise.
- R10: The first tone-mode edge after mode 2'b10 or 2'b11 gives `sample_o` = 128 (phase zero). Later samples follow from phase zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.579545 MHz timebase |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Mode word: 00 back channel, 01 forward channel, 10 off, 11 zero power |
| txd_i | input | 1 | Transmit data bit (1 = mark) |
| sample_o | output | 8 | Offset-binary sample code for the DAC |
| tone_on_o | output | 1 | High while a tone is being produced |

## Verification
Every result is due one clock after the inputs that cause it. The accumulator and the output register each add one edge. A sample therefore reflects the phase from before the latest edge, while mode and data act on the step from that edge on. The bench drives inputs on the falling edge. At each falling edge it compares both outputs with a behavioural model that was advanced on the preceding rising edge. Each comparison is tagged with the requirement that the current stimulus phase exercises.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;

    localparam int ACC_W  = 24;
    localparam int ADDR_W = 8;
    localparam int SAMP_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int HALF   = DEPTH / 2;
    localparam int AMP    = HALF - 1;
    localparam logic [SAMP_W-1:0] MID_CODE = SAMP_W'(HALF);

    typedef enum logic [1:0] {
        MODE_BACK  = 2'b00,
        MODE_FWD   = 2'b01,
        MODE_QUIET = 2'b10,
        MODE_SLEEP = 2'b11
    } tx_mode_e;

    typedef struct packed {
        logic             run;
        logic             sleep;
        logic [ACC_W-1:0] step;
    } tone_ctl_t;

    function automatic logic [ACC_W-1:0] freq_word(input longint f_hz, input longint clk_hz);
        longint num;
        num = (f_hz << ACC_W) + (clk_hz / 2);
        return ACC_W'(num / clk_hz);
    endfunction

    function automatic logic [SAMP_W-1:0] sine_code(input int idx);
        int q;
        int n;
        int d;
        int m;
        q = idx % HALF;
        n = 16 * q * (HALF - q);
        d = 5 * HALF * HALF - 4 * q * (HALF - q);
        m = (AMP * n) / d;
        if (idx < HALF) return SAMP_W'(HALF + m);
        else            return SAMP_W'(HALF - m);
    endfunction

endpackage

// File: rtl/fsk_word_sel.sv
module fsk_word_sel
    import fsk_tone_pkg::*;
#(
    parameter int CLK_HZ     = 3579545,
    parameter int BACK_SPACE = 450,
    parameter int BACK_MARK  = 390,
    parameter int FWD_SPACE  = 2100,
    parameter int FWD_MARK   = 1300
) (
    input  logic [1:0] mode_i,
    input  logic       txd_i,
    output tone_ctl_t  ctl_o
);
    localparam logic [ACC_W-1:0] W_BS = freq_word(BACK_SPACE, CLK_HZ);
    localparam logic [ACC_W-1:0] W_BM = freq_word(BACK_MARK,  CLK_HZ);
    localparam logic [ACC_W-1:0] W_FS = freq_word(FWD_SPACE,  CLK_HZ);
    localparam logic [ACC_W-1:0] W_FM = freq_word(FWD_MARK,   CLK_HZ);

    tx_mode_e mode;
    assign mode = tx_mode_e'(mode_i);

    always_comb begin
        ctl_o = '0;
        unique case (mode)
            MODE_BACK: begin
                ctl_o.run  = 1'b1;
                ctl_o.step = txd_i ? W_BM : W_BS;
            end
            MODE_FWD: begin
                ctl_o.run  = 1'b1;
                ctl_o.step = txd_i ? W_FM : W_FS;
            end
            MODE_SLEEP: ctl_o.sleep = 1'b1;
            default:    ctl_o.sleep = 1'b0;
        endcase
    end
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc
    import fsk_tone_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tone_ctl_t         ctl_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || !ctl_i.run) acc_q <= '0;
        else                   acc_q <= acc_q + ctl_i.step;
    end

    assign addr_o = acc_q[ACC_W-1 -: ADDR_W];
endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom
    import fsk_tone_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output logic [SAMP_W-1:0] code_o
);
    logic [SAMP_W-1:0] table_w [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        assign table_w[i] = sine_code(i);
    end

    assign code_o = table_w[addr_i];
endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen
    import fsk_tone_pkg::*;
#(
    parameter int CLK_HZ     = 3579545,
    parameter int BACK_SPACE = 450,
    parameter int BACK_MARK  = 390,
    parameter int FWD_SPACE  = 2100,
    parameter int FWD_MARK   = 1300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              txd_i,
    output logic [SAMP_W-1:0] sample_o,
    output logic              tone_on_o
);
    tone_ctl_t         ctl;
    logic [ADDR_W-1:0] addr;
    logic [SAMP_W-1:0] code;

    fsk_word_sel #(
        .CLK_HZ(CLK_HZ), .BACK_SPACE(BACK_SPACE), .BACK_MARK(BACK_MARK),
        .FWD_SPACE(FWD_SPACE), .FWD_MARK(FWD_MARK)
    ) u_sel (
        .mode_i(mode_i), .txd_i(txd_i), .ctl_o(ctl)
    );

    fsk_phase_acc u_acc (
        .clk(clk), .rst(rst), .ctl_i(ctl), .addr_o(addr)
    );

    fsk_sine_rom u_rom (
        .addr_i(addr), .code_o(code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_o  <= MID_CODE;
            tone_on_o <= 1'b0;
        end else if (ctl.run) begin
            sample_o  <= code;
            tone_on_o <= 1'b1;
        end else if (ctl.sleep) begin
            sample_o  <= '0;
            tone_on_o <= 1'b0;
        end else begin
            sample_o  <= MID_CODE;
            tone_on_o <= 1'b0;
        end
    end

    assert_quiet_mid_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b10) |=> (sample_o == MID_CODE));

    assert_sleep_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b11) |=> (sample_o == '0 && !tone_on_o));

    assert_flag_on_R9: assert property (@(posedge clk) disable iff (rst)
        (!mode_i[1]) |=> tone_on_o);

    assert_flag_off_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_i[1]) |=> !tone_on_o);

    assert_restart_phase_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_i[1] ##1 !mode_i[1]) |=> (sample_o == MID_CODE));
endmodule

// File: tb/fsk_tone_gen_bench.sv
module fsk_tone_gen_bench;
    localparam time CLK_PERIOD = 280ns;
    localparam int  WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_i = 2'b11;
    logic       txd_i = 1'b0;
    logic [7:0] sample_o;
    logic       tone_on_o;

    int checks = 0;
    int bad = 0;
    bit finished = 0;
    string cur_req = "R1";

    int m_acc = 0;
    int m_samp = 128;
    int m_act = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_tone_gen u_fsk_tone_gen (
        .clk(clk), .rst(rst), .mode_i(mode_i), .txd_i(txd_i),
        .sample_o(sample_o), .tone_on_o(tone_on_o)
    );

    function automatic int ref_step(input logic [1:0] md, input logic d);
        if (md == 2'b00) return d ? 1828 : 2109;
        if (md == 2'b01) return d ? 6093 : 9843;
        return 0;
    endfunction

    function automatic int ref_sine(input int a);
        int q;
        int m;
        q = a % 128;
        m = (127 * 16 * q * (128 - q)) / (81920 - 4 * q * (128 - q));
        return (a < 128) ? 128 + m : 128 - m;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_acc = 0; m_samp = 128; m_act = 0;
        end else if (mode_i[1] == 1'b0) begin
            m_samp = ref_sine(m_acc >> 16);
            m_act  = 1;
            m_acc  = (m_acc + ref_step(mode_i, txd_i)) & 24'hFFFFFF;
        end else if (mode_i == 2'b11) begin
            m_acc = 0; m_samp = 0; m_act = 0;
        end else begin
            m_acc = 0; m_samp = 128; m_act = 0;
        end
    end

    task automatic check_now();
        checks++;
        if (int'(sample_o) != m_samp) begin
            bad++;
            $display("FAIL %s sample actual=%0d expected=%0d at %0t", cur_req, sample_o, m_samp, $time);
        end
        checks++;
        if (int'(tone_on_o) != m_act) begin
            bad++;
            $display("FAIL %s tone_on actual=%0d expected=%0d at %0t", cur_req, tone_on_o, m_act, $time);
        end
    endtask

    task automatic run(input int n, input logic [1:0] md, input logic d, input int flip);
        mode_i = md;
        txd_i  = d;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now();
            if (flip > 0 && (i % flip) == flip - 1) txd_i = ~txd_i;
        end
    endtask

    task automatic check_window(input int step, input real lo, input real hi);
        real f;
        f = real'(step) * 3579545.0 / 16777216.0;
        checks++;
        if (f < lo || f > hi) begin
            bad++;
            $display("FAIL R4 tone actual=%f expected %f..%f", f, lo, hi);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check_now();
        rst = 1'b0;

        cur_req = "R4";
        check_window(2109, 448.0, 452.0);
        check_window(1828, 388.0, 392.0);
        check_window(9843, 2097.0, 2103.0);
        check_window(6093, 1297.0, 1303.0);

        cur_req = "R10"; run(4, 2'b00, 1'b0, 0);
        cur_req = "R2";  run(3000, 2'b00, 1'b0, 0);
        cur_req = "R2";  run(3000, 2'b00, 1'b1, 0);
        cur_req = "R5";  run(2000, 2'b01, 1'b0, 0);
        cur_req = "R3";  run(2000, 2'b01, 1'b1, 0);
        cur_req = "R6";  run(1500, 2'b01, 1'b0, 7);
        cur_req = "R6";  run(1500, 2'b00, 1'b1, 53);
        cur_req = "R7";  run(40, 2'b10, 1'b1, 3);
        cur_req = "R10"; run(600, 2'b01, 1'b1, 0);
        cur_req = "R8";  run(40, 2'b11, 1'b0, 5);
        cur_req = "R10"; run(600, 2'b00, 1'b0, 0);
        cur_req = "R9";  run(1, 2'b10, 1'b0, 0);
        cur_req = "R9";  run(1, 2'b01, 1'b0, 0);
        cur_req = "R9";  run(1, 2'b11, 1'b0, 0);
        cur_req = "R9";  run(300, 2'b01, 1'b0, 0);
        rst = 1'b1;
        cur_req = "R1";  run(2, 2'b01, 1'b0, 0);
        rst = 1'b0;
        cur_req = "R5";  run(500, 2'b01, 1'b1, 0);
        finish_run();
    end
endmodule